// File: doc/BRIEF.md
# Host-Acknowledged Two-Wire Bus Slave

This block is the slave half of a two-wire serial bus controller in which every acknowledge decision belongs to the host logic rather than to the block. It watches the clock and data lines through synchronizers and finds START and STOP conditions. It shifts in the first byte after a START and hands that whole raw byte to the host. The byte carries the direction flag in bit 0 and the 7-bit address in bits 7:1. The block then holds SCL low until the host answers with an acknowledge command. No address matching is done inside the block.

After an acknowledged address, the transfer runs at the host's pace. In a write transfer, each byte from the master is reported to the host before any ACK or NACK goes out, and SCL stays low until the host decides. In a read transfer, the block requests a byte, stretches SCL until the host supplies it, shifts it out MSB first, and reports the ACK or NACK that the master returns. Each time the host responds, SCL is released exactly one bit time later, which gives the data line a full low-phase setup. A STOP or a repeated START cancels any transfer in progress. The enable input works on its own, and the state register can be read at all times as an 8-bit code: four flag bits in the low nibble and an index in the high nibble.

Top module: `tws_host_slave`

## Requirements
- R1: While `en_i` is low the state code is 8'h00 and neither line is driven. Bus activity is ignored. Dropping `en_i` in any state releases both lines and clears `tx_req_o` on the next cycle. Raising it gives the idle code 8'h10.
- R2: After a START the block samples 8 bits MSB first on rising SCL edges. At the SCL fall after the 8th bit it drives the raw byte on `data_o` and pulses `addr_vld_o` for one cycle. The byte has R/W in bit 0 (1 = read) and the address in bits 7:1.
- R3: After an address byte or a write-data byte, SCL is held low (`scl_oe_o` = 1) with no time limit until the host pulses `ack_cmd_i`. The state code is 8'h33 after an address byte and 8'h67 after a data byte.
- R4: A host command (`ack_cmd_i` or `tx_cmd_i`) is taken at a clock edge. `scl_oe_o` stays high for exactly `BIT_CYC` cycles counted from that edge and then drops. The data line takes its new value at the edge where the command is taken.
- R5: `ack_val_i` = 1 drives SDA low for the ninth clock (state 8'h43). `ack_val_i` = 0 leaves SDA released, and after that clock the block parks in the hold code 8'hA1, where further bytes are ignored until a STOP or START.
- R6: In a write transfer (R/W = 0), each received byte appears on `data_o` with a one-cycle `rx_vld_o` pulse. At that moment SDA is not yet driven, so the ACK/NACK has not been sent.
- R7: After an acknowledged read address, and after each byte the master acknowledges, `tx_req_o` is high and SCL is held low (state 8'h7B) until `tx_cmd_i`. The byte from `tx_data_i` is then shifted out MSB first (state 8'h8D). SDA changes only while SCL is low.
- R8: On the ninth rising SCL edge of a read byte, `tx_done_o` pulses and `tx_ack_o` shows 1 if the master pulled SDA low (ACK) or 0 for a NACK (state 8'h9F). After an ACK the block requests the next byte. After a NACK it goes to the hold code 8'hA1.
- R9: A STOP in any enabled state returns the block to 8'h10. A repeated START goes to address reception, 8'h21, and any transfer in progress is dropped.
- R10: `ack_cmd_i` is ignored outside the two acknowledge-wait states. `tx_cmd_i` is ignored outside the read-request state. A repeated command during the release interval has no effect.
- R11: State code bits: bit 0 = active, bit 1 = busy (waiting on host or bus), bit 2 = data phase, bit 3 = transmitting; bits 7:4 index the state. Codes: disabled 00, idle 10, address 21, address wait 33, ack drive 43, receive 55, receive wait 67, transmit request 7B, transmit 8D, transmit ack 9F, hold A1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Slave enable |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe_o | output | 1 | Pull SCL low (clock stretch) |
| sda_oe_o | output | 1 | Pull SDA low |
| ack_cmd_i | input | 1 | Host acknowledge command pulse |
| ack_val_i | input | 1 | 1 = ACK, 0 = NACK, with `ack_cmd_i` |
| tx_cmd_i | input | 1 | Host transmit data command pulse |
| tx_data_i | input | 8 | Byte to send, with `tx_cmd_i` |
| addr_vld_o | output | 1 | Address byte on `data_o` (one cycle) |
| rx_vld_o | output | 1 | Write data byte on `data_o` (one cycle) |
| data_o | output | 8 | Last received raw byte |
| tx_req_o | output | 1 | Block waits for a byte from the host |
| tx_done_o | output | 1 | Read byte finished (one cycle) |
| tx_ack_o | output | 1 | Master response to the last read byte, 1 = ACK |
| state_o | output | 8 | State code (flags in 3:0, index in 7:4) |

## Verification
A wrong state shows up on the bus almost at once. A block stuck in a wait state keeps SCL low and stalls the master's next bit. A block that left a wait state early drops SCL before `BIT_CYC` cycles have passed, and the release count shows this. A byte or phase counter that is off by one shifts `data_o` by one bit, or moves the ACK drive off the ninth clock, within the same byte. A sweep over many address bytes, with both directions and both host answers, checks `state_o` at every phase boundary, so a misrouted transition is reported within one bit time of the edge that caused it.

// File: rtl/tws_pkg.sv
package tws_pkg;
  localparam int BYTE_W = 8;

  // low nibble: bit0 active, bit1 busy, bit2 data, bit3 tx; high nibble: index
  typedef enum logic [7:0] {
    ST_OFF      = 8'h00,
    ST_IDLE     = 8'h10,
    ST_ADDR     = 8'h21,
    ST_ADDR_WT  = 8'h33,
    ST_ACK_DRV  = 8'h43,
    ST_RX       = 8'h55,
    ST_RX_WT    = 8'h67,
    ST_TX_WT    = 8'h7B,
    ST_TX       = 8'h8D,
    ST_TX_ACK   = 8'h9F,
    ST_HOLD     = 8'hA1
  } tws_state_e;
endpackage

// File: rtl/tws_line_sync.sv
module tws_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int MSB = STAGES - 1;

  logic [MSB:0] scl_sh, sda_sh;
  logic         scl_q, sda_q, scl_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[MSB-1:0], scl_i};
      sda_sh <= {sda_sh[MSB-1:0], sda_i};
      scl_q  <= scl_sh[MSB];
      sda_q  <= sda_sh[MSB];
    end
  end

  assign scl_s      = scl_sh[MSB];
  assign sda_o      = sda_sh[MSB];
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  assign start_o    = scl_s & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/tws_stretch_timer.sv
module tws_stretch_timer #(
  parameter int BIT_CYC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic start_i,
  output logic armed_o,
  output logic expired_o
);
  localparam int CW = $clog2(BIT_CYC + 1);

  logic [CW-1:0] cnt;
  logic          armed;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed <= 1'b0;
      cnt   <= '0;
    end else if (clr_i) begin
      armed <= 1'b0;
      cnt   <= '0;
    end else if (start_i && !armed) begin
      armed <= 1'b1;
      cnt   <= CW'(BIT_CYC - 1);
    end else if (armed && cnt != '0) begin
      cnt <= cnt - CW'(1);
    end
  end

  assign armed_o   = armed;
  assign expired_o = armed && (cnt == '0);
endmodule

// File: rtl/tws_host_slave.sv
module tws_host_slave
  import tws_pkg::*;
#(
  parameter int BIT_CYC     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        en_i,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        scl_oe_o,
  output logic        sda_oe_o,
  input  logic        ack_cmd_i,
  input  logic        ack_val_i,
  input  logic        tx_cmd_i,
  input  logic [7:0]  tx_data_i,
  output logic        addr_vld_o,
  output logic        rx_vld_o,
  output logic [7:0]  data_o,
  output logic        tx_req_o,
  output logic        tx_done_o,
  output logic        tx_ack_o,
  output logic [7:0]  state_o
);
  localparam int BCW = $clog2(BYTE_W);
  localparam logic [BCW-1:0] LAST_BIT = BCW'(BYTE_W - 1);

  tws_state_e         state;
  logic [BYTE_W-1:0]  shreg;
  logic [BCW-1:0]     bitcnt;
  logic               full, rw_q, ack_q, mack_q;
  logic               sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic               in_wait, ack_wait, ack_take, tx_take, armed, expired;

  tws_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  assign ack_wait = (state == ST_ADDR_WT) || (state == ST_RX_WT);
  assign in_wait  = ack_wait || (state == ST_TX_WT);
  assign ack_take = ack_cmd_i && ack_wait && !armed;
  assign tx_take  = tx_cmd_i && (state == ST_TX_WT) && !armed;

  tws_stretch_timer #(.BIT_CYC(BIT_CYC)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (!in_wait),
    .start_i   (ack_take || tx_take),
    .armed_o   (armed),
    .expired_o (expired)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state      <= ST_OFF;
      shreg      <= '0;
      bitcnt     <= '0;
      full       <= 1'b0;
      rw_q       <= 1'b0;
      ack_q      <= 1'b0;
      mack_q     <= 1'b0;
      data_o     <= '0;
      addr_vld_o <= 1'b0;
      rx_vld_o   <= 1'b0;
      tx_done_o  <= 1'b0;
      tx_ack_o   <= 1'b0;
    end else begin
      addr_vld_o <= 1'b0;
      rx_vld_o   <= 1'b0;
      tx_done_o  <= 1'b0;
      if (!en_i) begin
        state  <= ST_OFF;
        bitcnt <= '0;
        full   <= 1'b0;
      end else if (state == ST_OFF) begin
        state <= ST_IDLE;
      end else if (start_det) begin
        state  <= ST_ADDR;
        bitcnt <= '0;
        full   <= 1'b0;
      end else if (stop_det) begin
        state <= ST_IDLE;
      end else begin
        unique case (state)
          ST_ADDR, ST_RX: begin
            if (scl_rise) begin
              shreg  <= {shreg[BYTE_W-2:0], sda_s};
              bitcnt <= bitcnt + BCW'(1);
              if (bitcnt == LAST_BIT) full <= 1'b1;
            end else if (scl_fall && full) begin
              full   <= 1'b0;
              data_o <= shreg;
              if (state == ST_ADDR) begin
                addr_vld_o <= 1'b1;
                rw_q       <= shreg[0];
                state      <= ST_ADDR_WT;
              end else begin
                rx_vld_o <= 1'b1;
                state    <= ST_RX_WT;
              end
            end
          end
          ST_ADDR_WT, ST_RX_WT: begin
            if (ack_take) ack_q <= ack_val_i;
            if (expired)  state <= ST_ACK_DRV;
          end
          ST_ACK_DRV: begin
            if (scl_fall) begin
              bitcnt <= '0;
              full   <= 1'b0;
              if (!ack_q)    state <= ST_HOLD;
              else if (rw_q) state <= ST_TX_WT;
              else           state <= ST_RX;
            end
          end
          ST_TX_WT: begin
            if (tx_take) shreg <= tx_data_i;
            if (expired) begin
              state  <= ST_TX;
              bitcnt <= '0;
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bitcnt == LAST_BIT) begin
                state <= ST_TX_ACK;
              end else begin
                shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                bitcnt <= bitcnt + BCW'(1);
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise) begin
              tx_done_o <= 1'b1;
              tx_ack_o  <= ~sda_s;
              mack_q    <= ~sda_s;
            end else if (scl_fall) begin
              state <= mack_q ? ST_TX_WT : ST_HOLD;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    unique case (state)
      ST_ADDR_WT, ST_RX_WT: sda_oe_o = armed && ack_q;
      ST_ACK_DRV:           sda_oe_o = ack_q;
      ST_TX_WT:             sda_oe_o = armed && !shreg[BYTE_W-1];
      ST_TX:                sda_oe_o = !shreg[BYTE_W-1];
      default:              sda_oe_o = 1'b0;
    endcase
  end

  assign scl_oe_o = in_wait;
  assign tx_req_o = (state == ST_TX_WT) && !armed;
  assign state_o  = state;
endmodule

// File: rtl/tws_host_slave_chk.sv
module tws_host_slave_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       en_i,
  input logic       scl_fall,
  input logic       start_det,
  input logic       stop_det,
  input logic       scl_oe_o,
  input logic       sda_oe_o,
  input logic       addr_vld_o,
  input logic       rx_vld_o,
  input logic       tx_req_o,
  input logic       tx_done_o,
  input logic [7:0] state_o
);
  // R1
  disable_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (state_o == 8'h00) && !scl_oe_o && !sda_oe_o);

  // R2
  addr_report_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_vld_o |-> (state_o == 8'h33) && scl_oe_o);

  // R6
  rx_before_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_vld_o |-> (state_o == 8'h67) && !sda_oe_o);

  // R7
  tx_req_stretch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_req_o |-> scl_oe_o && !sda_oe_o);

  // R7
  sda_low_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i) && !$past(start_det) && !$past(stop_det) && !$stable(sda_oe_o))
      |-> ($past(scl_fall) || scl_oe_o));

  // R8
  tx_done_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done_o |-> (state_o == 8'h9F));

  // R9
  stop_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && stop_det && (state_o != 8'h00)) |=> (state_o == 8'h10));
endmodule

bind tws_host_slave tws_host_slave_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .scl_fall   (scl_fall),
  .start_det  (start_det),
  .stop_det   (stop_det),
  .scl_oe_o   (scl_oe_o),
  .sda_oe_o   (sda_oe_o),
  .addr_vld_o (addr_vld_o),
  .rx_vld_o   (rx_vld_o),
  .tx_req_o   (tx_req_o),
  .tx_done_o  (tx_done_o),
  .state_o    (state_o)
);

// File: tb/tws_host_slave_tb.sv
module tws_host_slave_tb;
  localparam int BIT_CYC = 4;
  localparam int QC      = 6;
  localparam logic [7:0] S_OFF = 8'h00, S_IDLE = 8'h10, S_ADDR = 8'h21,
    S_AWT = 8'h33, S_RX = 8'h55, S_RWT = 8'h67, S_TWT = 8'h7B, S_HOLD = 8'hA1;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic ack_cmd = 1'b0, ack_val = 1'b0, tx_cmd = 1'b0;
  logic [7:0] tx_data = '0;
  logic scl_oe, sda_oe, addr_vld, rx_vld, tx_req, tx_done, tx_ack;
  logic [7:0] data, state;
  logic scl_line, sda_line;
  int checks = 0, errors = 0;
  int addr_cnt = 0, rx_cnt = 0, tx_cnt = 0;
  logic [7:0] addr_last = '0, rx_last = '0;
  logic rx_sda = 1'b0, tx_ack_last = 1'b0;

  always #4 clk = ~clk;

  assign scl_line = scl_m & ~scl_oe;
  assign sda_line = sda_m & ~sda_oe;

  tws_host_slave #(.BIT_CYC(BIT_CYC), .SYNC_STAGES(2)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .ack_cmd_i(ack_cmd), .ack_val_i(ack_val),
    .tx_cmd_i(tx_cmd), .tx_data_i(tx_data), .addr_vld_o(addr_vld), .rx_vld_o(rx_vld),
    .data_o(data), .tx_req_o(tx_req), .tx_done_o(tx_done), .tx_ack_o(tx_ack),
    .state_o(state)
  );

  always @(negedge clk) begin
    if (addr_vld) begin addr_cnt++; addr_last = data; end
    if (rx_vld) begin rx_cnt++; rx_last = data; rx_sda = sda_oe; end
    if (tx_done) begin tx_cnt++; tx_ack_last = tx_ack; end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic q();
    repeat (QC) @(negedge clk);
  endtask

  task automatic m_start();
    sda_m = 1'b1; q(); scl_m = 1'b1; wait (scl_line); q();
    sda_m = 1'b0; q(); scl_m = 1'b0; q();
  endtask

  task automatic m_stop();
    scl_m = 1'b0; sda_m = 1'b0; q(); scl_m = 1'b1; wait (scl_line); q();
    sda_m = 1'b1; q();
  endtask

  task automatic wr_bit(input logic b);
    sda_m = b; q(); scl_m = 1'b1; wait (scl_line); q(); scl_m = 1'b0; q();
  endtask

  task automatic rd_bit(output logic b);
    sda_m = 1'b1; q(); scl_m = 1'b1; wait (scl_line); q();
    b = sda_line; scl_m = 1'b0; q();
  endtask

  task automatic wr_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) wr_bit(b[i]);
  endtask

  task automatic rd_byte(output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      logic v;
      rd_bit(v);
      b[i] = v;
    end
  endtask

  // host answers an acknowledge wait, pokes ignored commands, measures release
  task automatic host_ack(input logic ack, input logic [7:0] wst);
    int cnt;
    wait (state == wst);
    @(negedge clk);
    tx_cmd = 1'b1; @(negedge clk); tx_cmd = 1'b0;
    repeat (8) @(negedge clk);
    chk("R3 stretch while waiting", {31'd0, scl_line}, 32'd0);
    chk("R10 tx_cmd ignored in ack wait", {24'd0, state}, {24'd0, wst});
    chk("R10 no sda before ack", {31'd0, sda_oe}, 32'd0);
    ack_val = ack; ack_cmd = 1'b1;
    @(negedge clk);
    ack_val = ~ack;
    chk("R4 sda set at command edge", {31'd0, sda_oe}, {31'd0, ack});
    cnt = 0;
    while (scl_oe && cnt < 64) begin
      cnt++;
      @(negedge clk);
      ack_cmd = 1'b0;
    end
    ack_cmd = 1'b0;
    chk("R4 release after bit time", cnt, BIT_CYC);
    chk("R10 repeated ack ignored", {31'd0, sda_oe}, {31'd0, ack});
  endtask

  task automatic host_tx(input logic [7:0] d);
    int cnt;
    wait (tx_req);
    @(negedge clk);
    ack_val = 1'b1; ack_cmd = 1'b1; @(negedge clk); ack_cmd = 1'b0;
    repeat (8) @(negedge clk);
    chk("R10 ack_cmd ignored in tx request", {30'd0, tx_req, scl_line}, 32'd2);
    chk("R7 no sda before data", {31'd0, sda_oe}, 32'd0);
    tx_data = d; tx_cmd = 1'b1;
    @(negedge clk);
    tx_cmd = 1'b0;
    chk("R4 first bit at command edge", {31'd0, sda_oe}, {31'd0, ~d[7]});
    cnt = 0;
    while (scl_oe && cnt < 64) begin
      cnt++;
      @(negedge clk);
    end
    chk("R4 tx release after bit time", cnt, BIT_CYC);
  endtask

  task automatic addr_phase(input logic [7:0] b, input logic ack);
    logic v;
    int n0;
    n0 = addr_cnt;
    m_start();
    chk("R9 start enters address", {24'd0, state}, {24'd0, S_ADDR});
    wr_byte(b);
    fork
      rd_bit(v);
      host_ack(ack, S_AWT);
    join
    chk("R2 one address report", addr_cnt - n0, 1);
    chk("R2 raw address byte", {24'd0, addr_last}, {24'd0, b});
    chk("R5 ack on ninth clock", {31'd0, ~v}, {31'd0, ack});
  endtask

  task automatic read_byte(input logic [7:0] d, input logic mack);
    logic [7:0] got;
    int n0;
    n0 = tx_cnt;
    fork
      host_tx(d);
      rd_byte(got);
    join
    chk("R7 byte shifted msb first", {24'd0, got}, {24'd0, d});
    wr_bit(~mack);
    chk("R8 one tx done", tx_cnt - n0, 1);
    chk("R8 master response", {31'd0, tx_ack_last}, {31'd0, mack});
    chk("R8 state after response", {24'd0, state}, {24'd0, mack ? S_TWT : S_HOLD});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset state", {24'd0, state}, {24'd0, S_OFF});
    chk("R1 reset lines", {30'd0, scl_oe, sda_oe}, 32'd0);
    m_start(); wr_byte(8'hA4); wr_bit(1'b1); m_stop();
    chk("R1 disabled ignores bus", addr_cnt, 0);
    chk("R1 disabled state", {24'd0, state}, {24'd0, S_OFF});
    en = 1'b1; repeat (2) @(negedge clk);
    chk("R11 idle code", {24'd0, state}, {24'd0, S_IDLE});

    // address sweep over both directions and both host answers
    for (int i = 0; i < 256; i += 3) begin
      logic [7:0] b;
      logic ack;
      b = 8'(i); ack = b[1];
      addr_phase(b, ack);
      if (!ack) begin
        chk("R5 nack parks in hold", {24'd0, state}, {24'd0, S_HOLD});
      end else if (b[0]) begin
        chk("R7 read request", {24'd0, state, 7'd0, tx_req}, {24'd0, S_TWT, 8'd1});
        read_byte(~b, 1'b0);
      end else begin
        chk("R11 receive code", {24'd0, state}, {24'd0, S_RX});
      end
      m_stop();
      chk("R9 stop to idle", {24'd0, state}, {24'd0, S_IDLE});
    end

    // write transfer with several data patterns, last byte nacked
    begin
      logic [7:0] pat [5];
      pat[0] = 8'h00; pat[1] = 8'hFF; pat[2] = 8'hA5; pat[3] = 8'h3C; pat[4] = 8'h81;
      addr_phase({7'h2D, 1'b0}, 1'b1);
      for (int k = 0; k < 5; k++) begin
        logic v;
        int n0;
        n0 = rx_cnt;
        wr_byte(pat[k]);
        fork
          rd_bit(v);
          host_ack(k != 4, S_RWT);
        join
        chk("R6 one data report", rx_cnt - n0, 1);
        chk("R6 data byte", {24'd0, rx_last}, {24'd0, pat[k]});
        chk("R6 reported before ack", {31'd0, rx_sda}, 32'd0);
        chk("R5 data ack bit", {31'd0, ~v}, {31'd0, k != 4});
      end
      chk("R5 hold after data nack", {24'd0, state}, {24'd0, S_HOLD});
      wr_byte(8'h77); wr_bit(1'b1);
      chk("R5 hold ignores bytes", rx_cnt, 5);
      m_stop();
    end

    // read transfer, several bytes acked, last nacked
    addr_phase({7'h51, 1'b1}, 1'b1);
    read_byte(8'h00, 1'b1);
    read_byte(8'hFF, 1'b1);
    read_byte(8'h96, 1'b0);
    m_stop();
    chk("R9 idle after read", {24'd0, state}, {24'd0, S_IDLE});

    // repeated start in the middle of a data byte
    addr_phase({7'h11, 1'b0}, 1'b1);
    wr_bit(1'b1); wr_bit(1'b0); wr_bit(1'b1);
    m_start();
    chk("R9 repeated start to address", {24'd0, state}, {24'd0, S_ADDR});
    chk("R9 partial byte dropped", rx_cnt, 5);
    wr_byte(8'hC3);
    begin
      logic v;
      fork
        rd_bit(v);
        host_ack(1'b1, S_AWT);
      join
    end
    chk("R2 address after restart", {24'd0, addr_last}, {24'd0, 8'hC3});
    read_byte(8'h5A, 1'b0);
    m_stop();

    // stop during address reception
    begin
      int n0;
      n0 = addr_cnt;
      m_start(); wr_bit(1'b1); wr_bit(1'b1); wr_bit(1'b0);
      m_stop();
      chk("R9 stop aborts address", addr_cnt - n0, 0);
      chk("R9 idle after abort", {24'd0, state}, {24'd0, S_IDLE});
    end

    // disable while a read request holds the bus
    addr_phase({7'h33, 1'b1}, 1'b1);
    wait (tx_req);
    repeat (4) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk("R1 disable releases bus", {29'd0, scl_oe, sda_oe, tx_req}, 32'd0);
    chk("R1 disable code", {24'd0, state}, {24'd0, S_OFF});
    m_stop();
    en = 1'b1; repeat (2) @(negedge clk);
    chk("R1 re-enable idle", {24'd0, state}, {24'd0, S_IDLE});

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule